// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the control-store address of the next microinstruction on every clock. It keeps three pieces of state: the current microaddress register, a second register holding the address that follows it (the next-next address), and a small return-address stack with its pointer. The fields of the microinstruction now being run drive the block: a 14-bit next-address field, a select for the current address, a select for the next-next address, a sequencer operation, a condition operation with its condition bit, a 4-bit dispatch value and a modifier that changes what the next-next select means.

The current address can come from the next-address field, from the stack top or from the next-next register. A conditional skip replaces only address bit 12 with the inverted condition. A conditional trap sends control to the next-address field, and it overrides the address select and the skip. A dispatch replaces bits 11:8 of the next-address field with the dispatch value and is loaded into the next-next register, so the branch takes effect one instruction later. A subroutine call pushes the current address plus one, and a return pops it. A dismiss request comes out as a one-cycle pulse to the task logic.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous active-low reset sets the current address to 0, the next-next address to 1, the stack pointer to 0 and every stack entry to 0, and clears all pulse outputs.
- R2: With no trap and no skip, the current-address select chooses the next current address as follows: 0 takes the next-address field, 1 takes the stack top as it was before this cycle's push or pop, and 2 takes the next-next register.
- R3: Current-address select code 3 is unused and behaves like code 0.
- R4: With the modifier low, a next-next select of 0 loads the dispatch address, which is the next-address field with bits 11:8 replaced by the dispatch value. A select of 1 loads the new current address plus 1, wrapping at 14 bits.
- R5: With the modifier high, a next-next select of 0 loads the current address of this cycle, and a select of 1 loads the stack top as it was before this cycle's push or pop.
- R6: Sequencer operation 1 (call) increments the stack pointer and writes the current address plus 1 into the new top. Operation 3 (return) decrements the pointer. Operation 0 does nothing.
- R7: Condition operation 1 (skip) sets bit 12 of the selected next address to the inverse of the condition bit and leaves all other bits as selected.
- R8: Condition operation 2 traps when the condition is 1 and operation 3 traps when it is 0. A trap loads the next-address field into the current address, overriding both the current-address select and any skip. Operation 0 ignores the condition.
- R9: The stack pointer wraps in both directions. A call made with the pointer at 15 raises the overflow output, and a return made with the pointer at 0 raises the underflow output, each for exactly the cycle after that edge.
- R10: Sequencer operation 2 (dismiss) raises the dismiss output for exactly the cycle after the edge. The stack is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| next_field | input | 14 | Next-address field of the current microinstruction |
| cur_sel | input | 2 | Current-address select (0 field, 1 stack top, 2 next-next, 3 as 0) |
| nn_sel | input | 1 | Next-next address select |
| seq_op | input | 2 | Sequencer operation (0 none, 1 call, 2 dismiss, 3 return) |
| cond_op | input | 2 | Condition operation (0 ignore, 1 skip, 2 trap on true, 3 trap on false) |
| cond_in | input | 1 | Condition bit |
| disp_val | input | 4 | Dispatch value, replaces bits 11:8 of the field |
| nn_magic | input | 1 | Modifier that changes the meaning of the next-next select |
| uaddr | output | 14 | Current microaddress |
| stack_top | output | 14 | Entry at the stack pointer |
| dismiss_pulse | output | 1 | One-cycle dismiss request |
| stk_overflow | output | 1 | One-cycle pointer overflow flag |
| stk_underflow | output | 1 | One-cycle pointer underflow flag |

## Verification
A wrong current address appears on uaddr on the first edge after the bad decision. A wrong next-next value is hidden until a later instruction selects it with current-address select 2, so the stimulus often follows a load with that select. A corrupted stack entry or pointer shows on stack_top right after the edge that writes it, or later when a return exposes the entry below. Long chains of calls and returns that wrap past 15 and 0 show a pointer fault on the flags and on the entries that come back.

// File: rtl/useq_pkg.sv
// Shared encodings for the microprogram next-address sequencer.
// Assumes 2-bit select and operation fields from the microinstruction.
package useq_pkg;
    typedef enum logic [1:0] {
        CSEL_FIELD = 2'd0,
        CSEL_STACK = 2'd1,
        CSEL_NEXT  = 2'd2,
        CSEL_SPARE = 2'd3
    } cur_sel_e;

    typedef enum logic [1:0] {
        SEQ_NONE    = 2'd0,
        SEQ_CALL    = 2'd1,
        SEQ_DISMISS = 2'd2,
        SEQ_RETURN  = 2'd3
    } seq_op_e;

    typedef enum logic [1:0] {
        COND_IGNORE    = 2'd0,
        COND_SKIP      = 2'd1,
        COND_TRAP_TRUE = 2'd2,
        COND_TRAP_FALS = 2'd3
    } cond_op_e;
endpackage

// File: rtl/useq_addr_sel.sv
// Combinational address choice for the sequencer.
// Computes the next current address (trap over skip over select) and the
// next-next address. Assumes the stack top given is the value before any
// push or pop this cycle.
module useq_addr_sel
    import useq_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int DISP_W   = 4,
    parameter int DISP_LSB = 8,
    parameter int SKIP_BIT = 12
) (
    input  logic [ADDR_W-1:0] field,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] nn_addr,
    input  logic [ADDR_W-1:0] top,
    input  logic [1:0]        cur_sel,
    input  logic              nn_sel,
    input  logic [1:0]        cond_op,
    input  logic              cond_in,
    input  logic [DISP_W-1:0] disp_val,
    input  logic              nn_magic,
    output logic [ADDR_W-1:0] cur_nxt,
    output logic [ADDR_W-1:0] nn_nxt
);
    localparam int DISP_MSB = DISP_LSB + DISP_W - 1;

    logic              trap;
    logic [ADDR_W-1:0] picked;
    logic [ADDR_W-1:0] disp_addr;

    // Trap decision from the condition operation.
    always_comb begin
        trap = ((cond_op == COND_TRAP_TRUE) && cond_in) ||
               ((cond_op == COND_TRAP_FALS) && !cond_in);
    end

    // Pick the source for the next current address and apply a skip.
    always_comb begin
        unique case (cur_sel)
            CSEL_STACK: picked = top;
            CSEL_NEXT:  picked = nn_addr;
            default:    picked = field;
        endcase
        if (cond_op == COND_SKIP) picked[SKIP_BIT] = ~cond_in;
        cur_nxt = trap ? field : picked;
    end

    // Dispatch address: field with one nibble swapped for the dispatch value.
    always_comb begin
        disp_addr = field;
        disp_addr[DISP_MSB:DISP_LSB] = disp_val;
    end

    // Next-next address, meaning changed by the modifier.
    always_comb begin
        if (nn_magic) nn_nxt = nn_sel ? top : cur_addr;
        else          nn_nxt = nn_sel ? ADDR_W'(cur_nxt + 1'b1) : disp_addr;
    end
endmodule

// File: rtl/useq_ctl_stack.sv
// Return-address stack with a wrapping pointer.
// A push writes wdata into the slot above the pointer and moves up; a pop
// moves down. Assumes push and pop are never requested together.
module useq_ctl_stack #(
    parameter int ADDR_W = 14,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] top,
    output logic              overflow,
    output logic              underflow
);
    localparam int SP_W = $clog2(DEPTH);
    localparam logic [SP_W-1:0] SP_MAX = SP_W'(DEPTH - 1);

    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   sp_up;
    logic [ADDR_W-1:0] slot [DEPTH];

    assign sp_up = sp + 1'b1;
    assign top   = slot[sp];

    // Pointer movement and one-cycle wrap flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp        <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            overflow  <= push && (sp == SP_MAX);
            underflow <= pop && (sp == '0);
            if (push)     sp <= sp_up;
            else if (pop) sp <= sp - 1'b1;
        end
    end

    // One storage register per entry, written on a push into its slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                               slot[g] <= '0;
            else if (push && (sp_up == SP_W'(g)))     slot[g] <= wdata;
        end
    end
endmodule

// File: rtl/useq_next_addr.sv
// Top of the next-address sequencer: holds the current and next-next address
// registers, drives the return-address stack and the dismiss pulse.
// Assumes the inputs are the fields of the microinstruction at uaddr.
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int DISP_W    = 4,
    parameter int DISP_LSB  = 8,
    parameter int SKIP_BIT  = 12,
    parameter int STK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] next_field,
    input  logic [1:0]        cur_sel,
    input  logic              nn_sel,
    input  logic [1:0]        seq_op,
    input  logic [1:0]        cond_op,
    input  logic              cond_in,
    input  logic [DISP_W-1:0] disp_val,
    input  logic              nn_magic,
    output logic [ADDR_W-1:0] uaddr,
    output logic [ADDR_W-1:0] stack_top,
    output logic              dismiss_pulse,
    output logic              stk_overflow,
    output logic              stk_underflow
);
    logic [ADDR_W-1:0] nn_reg;
    logic [ADDR_W-1:0] cur_nxt;
    logic [ADDR_W-1:0] nn_nxt;
    logic              do_push;
    logic              do_pop;

    assign do_push = (seq_op == SEQ_CALL);
    assign do_pop  = (seq_op == SEQ_RETURN);

    useq_addr_sel #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W),
        .DISP_LSB(DISP_LSB), .SKIP_BIT(SKIP_BIT)
    ) u_sel (
        .field(next_field), .cur_addr(uaddr), .nn_addr(nn_reg),
        .top(stack_top), .cur_sel(cur_sel), .nn_sel(nn_sel),
        .cond_op(cond_op), .cond_in(cond_in), .disp_val(disp_val),
        .nn_magic(nn_magic), .cur_nxt(cur_nxt), .nn_nxt(nn_nxt)
    );

    useq_ctl_stack #(.ADDR_W(ADDR_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
        .wdata(ADDR_W'(uaddr + 1'b1)), .top(stack_top),
        .overflow(stk_overflow), .underflow(stk_underflow)
    );

    // Address pipeline registers and the dismiss pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uaddr         <= '0;
            nn_reg        <= ADDR_W'(1);
            dismiss_pulse <= 1'b0;
        end else begin
            uaddr         <= cur_nxt;
            nn_reg        <= nn_nxt;
            dismiss_pulse <= (seq_op == SEQ_DISMISS);
        end
    end
endmodule

// File: rtl/useq_next_addr_chk.sv
// Property checker for the sequencer, bound to the top module.
module useq_next_addr_chk #(
    parameter int ADDR_W   = 14,
    parameter int SKIP_BIT = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] next_field,
    input logic [1:0]        cur_sel,
    input logic [1:0]        seq_op,
    input logic [1:0]        cond_op,
    input logic              cond_in,
    input logic [ADDR_W-1:0] uaddr,
    input logic [ADDR_W-1:0] stack_top,
    input logic              dismiss_pulse,
    input logic              stk_overflow,
    input logic              stk_underflow
);
    // R2
    field_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sel == 2'd0 && cond_op == 2'd0) |=> uaddr == $past(next_field));
    // R8
    trap_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_op == 2'd2 && cond_in) |=> uaddr == $past(next_field));
    // R8
    trap_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_op == 2'd3 && !cond_in) |=> uaddr == $past(next_field));
    // R7
    skip_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_op == 2'd1) |=> uaddr[SKIP_BIT] == !$past(cond_in));
    // R6
    call_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_op == 2'd1) |=> stack_top == ADDR_W'($past(uaddr) + 1'b1));
    // R10
    dismiss_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_op == 2'd2) |=> dismiss_pulse);
    // R10
    dismiss_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_op != 2'd2) |=> !dismiss_pulse);
    // R9
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_overflow |-> $past(seq_op) == 2'd1);
    // R9
    underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_underflow |-> $past(seq_op) == 2'd3);
endmodule

bind useq_next_addr useq_next_addr_chk #(.ADDR_W(ADDR_W), .SKIP_BIT(SKIP_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .next_field(next_field), .cur_sel(cur_sel),
    .seq_op(seq_op), .cond_op(cond_op), .cond_in(cond_in), .uaddr(uaddr),
    .stack_top(stack_top), .dismiss_pulse(dismiss_pulse),
    .stk_overflow(stk_overflow), .stk_underflow(stk_underflow)
);

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] next_field = '0;
    logic [1:0]  cur_sel = '0;
    logic        nn_sel = 1'b0;
    logic [1:0]  seq_op = '0;
    logic [1:0]  cond_op = '0;
    logic        cond_in = 1'b0;
    logic [3:0]  disp_val = '0;
    logic        nn_magic = 1'b0;
    logic [13:0] uaddr, stack_top;
    logic        dismiss_pulse, stk_overflow, stk_underflow;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench's own expected state.
    logic [13:0] e_cur, e_nn;
    logic [3:0]  e_sp;
    logic [13:0] e_stk [16];
    logic        e_dis, e_ovf, e_unf;

    always #5 clk = ~clk;

    useq_next_addr u_dut (
        .clk(clk), .rst_n(rst_n), .next_field(next_field), .cur_sel(cur_sel),
        .nn_sel(nn_sel), .seq_op(seq_op), .cond_op(cond_op), .cond_in(cond_in),
        .disp_val(disp_val), .nn_magic(nn_magic), .uaddr(uaddr),
        .stack_top(stack_top), .dismiss_pulse(dismiss_pulse),
        .stk_overflow(stk_overflow), .stk_underflow(stk_underflow)
    );

    function automatic logic [13:0] exp_cur(logic [13:0] f, logic [1:0] cs,
                                            logic [1:0] co, logic c);
        logic [13:0] p;
        if (cs == 2'd1)      p = e_stk[e_sp];
        else if (cs == 2'd2) p = e_nn;
        else                 p = f;
        if (co == 2'd1) p[12] = ~c;
        if ((co == 2'd2 && c) || (co == 2'd3 && !c)) p = f;
        return p;
    endfunction

    task automatic reset_model();
        e_cur = '0; e_nn = 14'd1; e_sp = '0;
        e_dis = 0; e_ovf = 0; e_unf = 0;
        for (int i = 0; i < 16; i++) e_stk[i] = '0;
    endtask

    task automatic check_all(string tag);
        checks++;
        if (uaddr !== e_cur || stack_top !== e_stk[e_sp] || dismiss_pulse !== e_dis ||
            stk_overflow !== e_ovf || stk_underflow !== e_unf) begin
            failures++;
            $display("FAIL %s: addr=%h top=%h dis=%b ovf=%b unf=%b expected addr=%h top=%h dis=%b ovf=%b unf=%b",
                     tag, uaddr, stack_top, dismiss_pulse, stk_overflow, stk_underflow,
                     e_cur, e_stk[e_sp], e_dis, e_ovf, e_unf);
        end
    endtask

    // Apply one microinstruction, advance the model, and check after the edge.
    task automatic step(string tag, logic [13:0] f, logic [1:0] cs, logic ns,
                        logic [1:0] so, logic [1:0] co, logic c, logic [3:0] d, logic m);
        logic [13:0] nc, nn;
        logic [13:0] old_top;
        next_field = f; cur_sel = cs; nn_sel = ns; seq_op = so;
        cond_op = co; cond_in = c; disp_val = d; nn_magic = m;
        old_top = e_stk[e_sp];
        nc = exp_cur(f, cs, co, c);
        if (m) nn = ns ? old_top : e_cur;
        else   nn = ns ? 14'(nc + 1) : {f[13:12], d, f[7:0]};
        e_ovf = (so == 2'd1) && (e_sp == 4'd15);
        e_unf = (so == 2'd3) && (e_sp == 4'd0);
        e_dis = (so == 2'd2);
        if (so == 2'd1) begin
            e_sp = e_sp + 1'b1;
            e_stk[e_sp] = 14'(e_cur + 1);
        end else if (so == 2'd3) begin
            e_sp = e_sp - 1'b1;
        end
        e_cur = nc; e_nn = nn;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: expected finish got timeout");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        reset_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset state");
        // R1: the next-next register starts at 1.
        step("R1 nn after reset", 14'h0, 2'd2, 0, 0, 0, 0, 4'h0, 0);
        // R2: field, stack top, next-next.
        step("R2 field", 14'h1234, 2'd0, 1, 0, 0, 0, 4'h0, 0);
        step("R2 next-next", 14'h0abc, 2'd2, 0, 0, 0, 0, 4'h0, 0);
        // R3: code 3 behaves like code 0.
        step("R3 spare select", 14'h2f0f, 2'd3, 0, 0, 0, 1, 4'h0, 0);
        // R4: dispatch then load with select 2.
        step("R4 dispatch load", 14'h3a5c, 2'd0, 0, 0, 0, 0, 4'h9, 0);
        step("R4 dispatch used", 14'h0000, 2'd2, 1, 0, 0, 0, 4'h0, 0);
        // R4: increment wraps.
        step("R4 wrap", 14'h3fff, 2'd0, 1, 0, 0, 0, 4'h0, 0);
        step("R4 wrap used", 14'h0001, 2'd2, 0, 0, 0, 0, 4'h0, 0);
        // R6: call and return.
        step("R6 call", 14'h0100, 2'd0, 0, 2'd1, 0, 0, 4'h0, 0);
        step("R6 second call", 14'h0200, 2'd0, 0, 2'd1, 0, 0, 4'h0, 0);
        step("R2 stack top", 14'h0000, 2'd1, 0, 2'd3, 0, 0, 4'h0, 0);
        step("R6 return", 14'h0000, 2'd1, 0, 2'd3, 0, 0, 4'h0, 0);
        // R5: modifier selects.
        step("R5 magic cur", 14'h0777, 2'd0, 0, 2'd1, 0, 0, 4'h0, 1);
        step("R5 magic cur used", 14'h0000, 2'd2, 1, 0, 0, 0, 4'h0, 1);
        step("R5 magic top used", 14'h0000, 2'd2, 0, 0, 0, 0, 4'h0, 0);
        // R7: skip with condition 0 and 1.
        step("R7 skip false", 14'h0055, 2'd0, 0, 0, 2'd1, 0, 4'h0, 0);
        step("R7 skip true", 14'h1055, 2'd0, 0, 0, 2'd1, 1, 4'h0, 0);
        // R8: trap over select; non-trap cases.
        step("R8 trap true", 14'h2222, 2'd2, 0, 0, 2'd2, 1, 4'h0, 0);
        step("R8 no trap true", 14'h2223, 2'd2, 0, 0, 2'd2, 0, 4'h0, 0);
        step("R8 trap false", 14'h3333, 2'd1, 0, 0, 2'd3, 0, 4'h0, 0);
        step("R8 no trap false", 14'h3334, 2'd0, 0, 0, 2'd3, 1, 4'h0, 0);
        step("R8 ignore", 14'h1111, 2'd0, 0, 0, 2'd0, 1, 4'h0, 0);
        // R10: dismiss pulse for one cycle.
        step("R10 dismiss", 14'h0042, 2'd0, 0, 2'd2, 0, 0, 4'h0, 0);
        step("R10 dismiss drop", 14'h0043, 2'd0, 0, 2'd0, 0, 0, 4'h0, 0);
        // R9: wrap in both directions.
        for (int i = 0; i < 18; i++)
            step("R9 call wrap", 14'(i * 3), 2'd0, 0, 2'd1, 0, 0, 4'h0, 0);
        for (int i = 0; i < 20; i++)
            step("R9 return wrap", 14'(i), 2'd1, 0, 2'd3, 0, 0, 4'h0, 0);
        // Random mix over every requirement (R2 R4 R5 R6 R7 R8 R9 R10).
        for (int i = 0; i < 3000; i++)
            step("R2 R4 R5 R6 R7 R8 R9 R10 random", 14'($urandom), 2'($urandom),
                 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
                 4'($urandom), 1'($urandom));
        // R1: reset again from a busy state.
        rst_n = 1'b0;
        reset_model();
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 second reset");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule